// File: doc/BRIEF.md
# Eight-Stage Clock Sample Filter

This block filters the timing samples collected for a single time-server peer. Each sample has three parts: a signed clock offset, an unsigned round-trip delay and a dispersion. All three are in fixed-point microseconds. The block keeps the last eight samples in a window. A new measured sample, or a placeholder pushed in while the peer cannot be reached, enters at the young end of the window, and the oldest entry falls out. A one-second tick pulse ages every stored dispersion.

After each update the block picks the stage with the lowest delay. It will not go back in time: a stage is adopted only when it is younger than the current choice and has a strictly lower delay, or when the current choice has left the window. From the window and the chosen stage the block derives five results: peer offset, peer delay, a dispersion sum weighted by powers of two, a mean-square jitter, and a synchronization distance with a flag that marks it usable. Taking the square root of the jitter is left to the consumer.

Top module: `clk_sample_filter`

## Requirements
- R1: A sample pulse shifts the window by one stage. The new sample enters stage 0, the youngest. Stage k moves to stage k+1, and stage 7 is discarded.
- R2: A new sample's dispersion is the server precision plus the client precision. The result is limited to the infinity value of 16,000,000.
- R3: A tick pulse adds 15 to every stored dispersion, saturating at 16,000,000. When a tick and a shift occur in the same cycle, the stored stages are aged first and the new entry is not aged.
- R4: Reset sets every stage to offset 0, delay 2^DLY_W-1 and dispersion 16,000,000, and clears the selection. All outputs read zero and out_valid_o is low.
- R5: A pulse on unreach_i without a sample pulse shifts in a placeholder with offset 0, maximum delay and dispersion 16,000,000. Eight placeholders restore the reset window. If a sample pulse and unreach_i arrive in the same cycle, the sample wins.
- R6: Selection takes the stage with the minimum delay, preferring the youngest stage on ties. The selected stage's offset and delay drive peer_off_o and peer_dly_o.
- R7: Causality. The current selection is kept, moving with the shifts, until a younger stage has a strictly lower delay. If the selected stage has been shifted out, or there is no selection yet, the minimum is adopted.
- R8: peer_disp_o is the sum over stages i = 0..7 of dispersion[i] >> (i+1).
- R9: peer_jit_o is the sum over the eight stages of (offset[i] - selected offset)^2, shifted right by 3.
- R10: sync_dist_o is (peer delay >> 1) + peer_disp_o. sync_ok_o is high exactly when sync_dist_o < 1,500,000.
- R11: All outputs register in the cycle after a sample, unreach or tick pulse, and out_valid_o is high for that one cycle only. In every other cycle the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | New measured sample pulse |
| unreach_i | input | 1 | Peer-unreachable pulse, pushes a placeholder |
| tick_i | input | 1 | One-second aging pulse |
| smp_off_i | input | OFF_W | Signed sample offset, µs |
| smp_dly_i | input | DLY_W | Sample round-trip delay, µs |
| prec_srv_i | input | PREC_W | Server precision, µs |
| prec_cli_i | input | PREC_W | Client precision, µs |
| peer_off_o | output | OFF_W | Selected offset (signed) |
| peer_dly_o | output | DLY_W | Selected delay |
| peer_disp_o | output | DSP_W | Weighted dispersion sum |
| peer_jit_o | output | 2*OFF_W+2 | Mean-square jitter |
| sync_dist_o | output | max(DLY_W,DSP_W)+1 | Synchronization distance |
| sync_ok_o | output | 1 | Distance below threshold |
| out_valid_o | output | 1 | Output update strobe |

## Verification
The bench targets these cases:
- **Delay ties.** A design that adopts the younger of two equal delays would jump forward to a sample that is no better, so the bench checks that the older selection is kept.
- **Selection leaving the window.** A design that keeps a stale index once the selected stage falls off the end would report an offset no longer held in the window. The bench checks that a design that does this is caught.
- **Same-cycle pulses.** A tick with a sample, or a sample with an unreachable pulse, exposes designs that age the incoming sample or let the placeholder win. Either mistake shifts the dispersion sum or the selected delay by a known amount.
- **Placeholder flooding.** Eight placeholders must return the sum to exactly 15,937,500. Lost saturation or a wrong weight shift would show in that value.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int unsigned CF_STAGES   = 8;
  localparam int unsigned CF_INF_US   = 16_000_000;
  localparam int unsigned CF_AGE_STEP = 15;
  localparam int unsigned CF_SYNC_THR = 1_500_000;
endpackage

// File: rtl/cf_window.sv
module cf_window #(
  parameter int unsigned N      = 8,
  parameter int unsigned OFF_W  = 24,
  parameter int unsigned DLY_W  = 24,
  parameter int unsigned DSP_W  = 24,
  parameter int unsigned PREC_W = 16,
  parameter int unsigned INF    = 16_000_000,
  parameter int unsigned STEP   = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_i,
  input  logic                    dum_i,
  input  logic                    tick_i,
  input  logic signed [OFF_W-1:0] off_i,
  input  logic [DLY_W-1:0]        dly_i,
  input  logic [PREC_W-1:0]       prec_srv_i,
  input  logic [PREC_W-1:0]       prec_cli_i,
  output logic                    shift_o,
  output logic signed [OFF_W-1:0] off_n_o [N],
  output logic [DLY_W-1:0]        dly_n_o [N],
  output logic [DSP_W-1:0]        dsp_n_o [N]
);
  localparam logic [DSP_W-1:0] INF_V   = DSP_W'(INF);
  localparam logic [DSP_W-1:0] STEP_V  = DSP_W'(STEP);
  localparam logic [DLY_W-1:0] DLY_MAX = '1;

  logic signed [OFF_W-1:0] off_q [N];
  logic [DLY_W-1:0]        dly_q [N];
  logic [DSP_W-1:0]        dsp_q [N];
  logic [DSP_W-1:0]        aged  [N];
  logic [PREC_W:0]         prec_sum;
  logic [DSP_W-1:0]        new_dsp;

  assign shift_o  = smp_i | dum_i;
  assign prec_sum = {1'b0, prec_srv_i} + {1'b0, prec_cli_i};
  assign new_dsp  = (DSP_W'(prec_sum) >= INF_V) ? INF_V : DSP_W'(prec_sum);

  // aging happens before the shift
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (tick_i) aged[i] = (dsp_q[i] >= INF_V - STEP_V) ? INF_V : dsp_q[i] + STEP_V;
      else        aged[i] = dsp_q[i];
    end
  end

  always_comb begin
    if (smp_i) begin
      off_n_o[0] = off_i;
      dly_n_o[0] = dly_i;
      dsp_n_o[0] = new_dsp;
    end else if (dum_i) begin
      off_n_o[0] = '0;
      dly_n_o[0] = DLY_MAX;
      dsp_n_o[0] = INF_V;
    end else begin
      off_n_o[0] = off_q[0];
      dly_n_o[0] = dly_q[0];
      dsp_n_o[0] = aged[0];
    end
    for (int i = 1; i < N; i++) begin
      off_n_o[i] = shift_o ? off_q[i-1] : off_q[i];
      dly_n_o[i] = shift_o ? dly_q[i-1] : dly_q[i];
      dsp_n_o[i] = shift_o ? aged[i-1]  : aged[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        off_q[i] <= '0;
        dly_q[i] <= DLY_MAX;
        dsp_q[i] <= INF_V;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        off_q[i] <= off_n_o[i];
        dly_q[i] <= dly_n_o[i];
        dsp_q[i] <= dsp_n_o[i];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_stage_chk
    AST_DSP_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dsp_q[g] <= INF_V); // R3
    AST_TICK_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !shift_o) |=> dsp_q[g] >= $past(dsp_q[g])); // R3
  end

  for (genvar g = 1; g < N; g++) begin : g_shift_chk
    AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_o |=> (dly_q[g] == $past(dly_q[g-1])) && (off_q[g] == $past(off_q[g-1]))); // R1
  end

  AST_SMP_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_i |=> (dly_q[0] == $past(dly_i)) && (off_q[0] == $past(off_i))); // R1
  AST_DUMMY_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dum_i && !smp_i) |=> (dly_q[0] == DLY_MAX) && (dsp_q[0] == INF_V) && (off_q[0] == '0)); // R5
endmodule

// File: rtl/cf_select.sv
module cf_select #(
  parameter int unsigned N     = 8,
  parameter int unsigned DLY_W = 24,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             shift_i,
  input  logic [DLY_W-1:0] dly_i [N],
  output logic [IDX_W-1:0] sel_o
);
  logic             sel_vld_q;
  logic [IDX_W-1:0] sel_pos_q;
  logic [IDX_W-1:0] min_idx;
  logic [DLY_W-1:0] min_dly;
  logic [IDX_W:0]   pos;
  logic             lost, adopt;

  // scan from oldest so ties resolve to the youngest stage
  always_comb begin
    min_idx = IDX_W'(N-1);
    min_dly = dly_i[N-1];
    for (int i = int'(N) - 2; i >= 0; i--) begin
      if (dly_i[i] <= min_dly) begin
        min_dly = dly_i[i];
        min_idx = IDX_W'(i);
      end
    end
  end

  assign pos   = {1'b0, sel_pos_q} + (IDX_W+1)'(shift_i);
  assign lost  = pos >= (IDX_W+1)'(N);
  assign adopt = !sel_vld_q || lost ||
                 (({1'b0, min_idx} < pos) && (min_dly < dly_i[pos[IDX_W-1:0]]));
  assign sel_o = adopt ? min_idx : pos[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_vld_q <= 1'b0;
      sel_pos_q <= '0;
    end else if (upd_i) begin
      sel_vld_q <= 1'b1;
      sel_pos_q <= sel_o;
    end
  end

  AST_SEL_NO_OLDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && shift_i && sel_vld_q && (sel_pos_q < IDX_W'(N-1)))
    |=> ({1'b0, sel_pos_q} <= {1'b0, $past(sel_pos_q)} + (IDX_W+1)'(1))); // R7
  AST_SEL_KEEP_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !shift_i && sel_vld_q) |=> (sel_pos_q == $past(sel_pos_q))); // R7
endmodule

// File: rtl/cf_stats.sv
module cf_stats #(
  parameter int unsigned N     = 8,
  parameter int unsigned OFF_W = 24,
  parameter int unsigned DSP_W = 24,
  localparam int unsigned JIT_W = 2*OFF_W + 2,
  localparam int unsigned SH    = $clog2(N)
) (
  input  logic signed [OFF_W-1:0] off_i [N],
  input  logic [DSP_W-1:0]        dsp_i [N],
  input  logic signed [OFF_W-1:0] sel_off_i,
  output logic [DSP_W-1:0]        disp_o,
  output logic [JIT_W-1:0]        jit_o
);
  logic [JIT_W+SH-1:0]     sq_acc;
  logic signed [OFF_W:0]   diff;
  logic signed [JIT_W-1:0] sq;

  always_comb begin
    disp_o = '0;
    for (int i = 0; i < N; i++) disp_o = disp_o + (dsp_i[i] >> (i + 1));
  end

  always_comb begin
    sq_acc = '0;
    diff   = '0;
    sq     = '0;
    for (int i = 0; i < N; i++) begin
      diff   = {off_i[i][OFF_W-1], off_i[i]} - {sel_off_i[OFF_W-1], sel_off_i};
      sq     = diff * diff;
      sq_acc = sq_acc + {{SH{1'b0}}, sq};
    end
    jit_o = JIT_W'(sq_acc >> SH);
  end
endmodule

// File: rtl/clk_sample_filter.sv
module clk_sample_filter
  import cf_pkg::*;
#(
  parameter int unsigned N      = CF_STAGES,
  parameter int unsigned OFF_W  = 24,
  parameter int unsigned DLY_W  = 24,
  parameter int unsigned DSP_W  = 24,
  parameter int unsigned PREC_W = 16,
  parameter int unsigned INF    = CF_INF_US,
  parameter int unsigned STEP   = CF_AGE_STEP,
  parameter int unsigned THR    = CF_SYNC_THR,
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned JIT_W  = 2*OFF_W + 2,
  localparam int unsigned DIST_W = ((DLY_W > DSP_W) ? DLY_W : DSP_W) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_vld_i,
  input  logic                     unreach_i,
  input  logic                     tick_i,
  input  logic signed [OFF_W-1:0]  smp_off_i,
  input  logic [DLY_W-1:0]         smp_dly_i,
  input  logic [PREC_W-1:0]        prec_srv_i,
  input  logic [PREC_W-1:0]        prec_cli_i,
  output logic signed [OFF_W-1:0]  peer_off_o,
  output logic [DLY_W-1:0]         peer_dly_o,
  output logic [DSP_W-1:0]         peer_disp_o,
  output logic [JIT_W-1:0]         peer_jit_o,
  output logic [DIST_W-1:0]        sync_dist_o,
  output logic                     sync_ok_o,
  output logic                     out_valid_o
);
  logic                    shift, upd;
  logic signed [OFF_W-1:0] off_n [N];
  logic [DLY_W-1:0]        dly_n [N];
  logic [DSP_W-1:0]        dsp_n [N];
  logic [IDX_W-1:0]        sel;
  logic [DSP_W-1:0]        disp_n;
  logic [JIT_W-1:0]        jit_n;
  logic [DIST_W-1:0]       dist_n;

  assign upd = smp_vld_i | unreach_i | tick_i;

  cf_window #(
    .N(N), .OFF_W(OFF_W), .DLY_W(DLY_W), .DSP_W(DSP_W),
    .PREC_W(PREC_W), .INF(INF), .STEP(STEP)
  ) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .smp_i(smp_vld_i), .dum_i(unreach_i), .tick_i(tick_i),
    .off_i(smp_off_i), .dly_i(smp_dly_i),
    .prec_srv_i(prec_srv_i), .prec_cli_i(prec_cli_i),
    .shift_o(shift), .off_n_o(off_n), .dly_n_o(dly_n), .dsp_n_o(dsp_n)
  );

  cf_select #(.N(N), .DLY_W(DLY_W)) u_select (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .shift_i(shift),
    .dly_i(dly_n), .sel_o(sel)
  );

  cf_stats #(.N(N), .OFF_W(OFF_W), .DSP_W(DSP_W)) u_stats (
    .off_i(off_n), .dsp_i(dsp_n), .sel_off_i(off_n[sel]),
    .disp_o(disp_n), .jit_o(jit_n)
  );

  assign dist_n = DIST_W'(dly_n[sel] >> 1) + DIST_W'(disp_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peer_off_o  <= '0;
      peer_dly_o  <= '0;
      peer_disp_o <= '0;
      peer_jit_o  <= '0;
      sync_dist_o <= '0;
      sync_ok_o   <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= upd;
      if (upd) begin
        peer_off_o  <= off_n[sel];
        peer_dly_o  <= dly_n[sel];
        peer_disp_o <= disp_n;
        peer_jit_o  <= jit_n;
        sync_dist_o <= dist_n;
        sync_ok_o   <= dist_n < DIST_W'(THR);
      end
    end
  end

  AST_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> out_valid_o); // R11
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> !out_valid_o && $stable(peer_off_o) && $stable(peer_disp_o) && $stable(sync_dist_o)); // R11
  AST_SYNC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (sync_ok_o == (sync_dist_o < DIST_W'(THR)))); // R10
endmodule

// File: tb/clk_sample_filter_test.sv
module clk_sample_filter_test;
  localparam longint INF  = 16000000;
  localparam longint DMAX = 64'hFFFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp = 1'b0, unr = 1'b0, tick = 1'b0;
  logic signed [23:0] off_in = '0;
  logic [23:0] dly_in = '0;
  logic [15:0] ps = '0, pc = '0;
  logic signed [23:0] peer_off;
  logic [23:0] peer_dly, peer_disp;
  logic [49:0] peer_jit;
  logic [24:0] sync_dist;
  logic sync_ok, out_valid;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  longint m_off [8];
  longint m_dly [8];
  longint m_dsp [8];
  bit m_sv;
  int m_sp;

  always #4 clk = ~clk;

  clk_sample_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(smp), .unreach_i(unr), .tick_i(tick),
    .smp_off_i(off_in), .smp_dly_i(dly_in), .prec_srv_i(ps), .prec_cli_i(pc),
    .peer_off_o(peer_off), .peer_dly_o(peer_dly), .peer_disp_o(peer_disp),
    .peer_jit_o(peer_jit), .sync_dist_o(sync_dist), .sync_ok_o(sync_ok),
    .out_valid_o(out_valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin
      m_off[i] = 0; m_dly[i] = DMAX; m_dsp[i] = INF;
    end
    m_sv = 0; m_sp = 0;
  endtask

  function automatic longint e_disp();
    longint a = 0;
    for (int i = 0; i < 8; i++) a += m_dsp[i] >> (i + 1);
    return a;
  endfunction

  function automatic longint e_jit();
    longint a = 0;
    for (int i = 0; i < 8; i++) a += (m_off[i] - m_off[m_sp]) * (m_off[i] - m_off[m_sp]);
    return a >> 3;
  endfunction

  task automatic m_apply(input bit s, input bit d, input bit t, input longint o,
                         input longint dl, input longint p1, input longint p2);
    bit sh;
    int pos, mi;
    if (t) for (int i = 0; i < 8; i++) m_dsp[i] = (m_dsp[i] + 15 > INF) ? INF : m_dsp[i] + 15;
    sh = s | d;
    if (sh) begin
      for (int i = 7; i > 0; i--) begin
        m_off[i] = m_off[i-1]; m_dly[i] = m_dly[i-1]; m_dsp[i] = m_dsp[i-1];
      end
      if (s) begin
        m_off[0] = o; m_dly[0] = dl; m_dsp[0] = (p1 + p2 > INF) ? INF : p1 + p2;
      end else begin
        m_off[0] = 0; m_dly[0] = DMAX; m_dsp[0] = INF;
      end
    end
    mi = 7;
    for (int i = 6; i >= 0; i--) if (m_dly[i] <= m_dly[mi]) mi = i;
    pos = m_sp + (sh ? 1 : 0);
    if (!m_sv || pos > 7 || (mi < pos && m_dly[mi] < m_dly[pos])) m_sp = mi;
    else m_sp = pos;
    m_sv = 1;
  endtask

  task automatic do_op(input bit s, input bit d, input bit t, input longint o,
                       input longint dl, input longint p1, input longint p2);
    longint hold_disp, hold_off;
    @(negedge clk);
    smp = s; unr = d; tick = t;
    off_in = 24'(o); dly_in = 24'(dl); ps = 16'(p1); pc = 16'(p2);
    @(negedge clk);
    smp = 0; unr = 0; tick = 0;
    m_apply(s, d, t, o, dl, p1, p2);
    chk("R11 out_valid strobe", longint'(out_valid), 1);
    chk("R6 peer offset", longint'(peer_off), m_off[m_sp]);
    chk("R6 peer delay", longint'(peer_dly), m_dly[m_sp]);
    chk("R8 peer dispersion", longint'(peer_disp), e_disp());
    chk("R9 jitter", longint'(peer_jit), e_jit());
    chk("R10 distance", longint'(sync_dist), (m_dly[m_sp] >> 1) + e_disp());
    chk("R10 sync flag", longint'(sync_ok), ((m_dly[m_sp] >> 1) + e_disp() < 1500000) ? 1 : 0);
    hold_disp = longint'(peer_disp);
    hold_off  = longint'(peer_off);
    @(negedge clk);
    chk("R11 strobe drops", longint'(out_valid), 0);
    chk("R11 outputs hold", longint'(peer_disp) + longint'(peer_off), hold_disp + hold_off);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset offset", longint'(peer_off), 0);
    chk("R4 reset dispersion", longint'(peer_disp), 0);
    chk("R4 reset valid", longint'(out_valid), 0);
    chk("R4 reset flag", longint'(sync_ok), 0);

    // first sample after reset: R2, R4 window contents, R9
    do_op(1, 0, 0, 7, 1000, 300, 200);
    chk("R2 new dispersion", longint'(peer_disp), 7937750);
    chk("R9 jitter vs reset stages", longint'(peer_jit), 42);
    do_op(0, 0, 1, 0, 0, 0, 0);
    chk("R3 tick ages", longint'(peer_disp), 7937757);
    do_op(1, 0, 1, -3, 2000, 100, 100);
    chk("R3 tick before shift", longint'(peer_disp), 3937732);
    chk("R7 older lower kept", longint'(peer_off), 7);
    chk("R1 shifted stage delay", longint'(peer_dly), 1000);

    // causality under ties
    reset_dut();
    do_op(1, 0, 0, 1, 500, 10, 10);
    do_op(1, 0, 0, 2, 300, 10, 10);
    do_op(1, 0, 0, 3, 400, 10, 10);
    do_op(1, 0, 0, 4, 350, 10, 10);
    chk("R6 min delay selected", longint'(peer_off), 2);
    do_op(1, 0, 0, 5, 300, 10, 10);
    chk("R7 tie keeps older", longint'(peer_off), 2);
    do_op(1, 0, 0, 6, 250, 10, 10);
    chk("R7 younger lower adopted", longint'(peer_off), 6);

    // selection shifted out
    reset_dut();
    do_op(1, 0, 0, 9, 100, 5, 5);
    for (int k = 0; k < 7; k++) do_op(1, 0, 0, 20 + k, 500, 5, 5);
    chk("R1 oldest still held", longint'(peer_off), 9);
    do_op(1, 0, 0, 40, 900, 5, 5);
    chk("R7 shifted out readopt", longint'(peer_off), 26);
    chk("R7 shifted out delay", longint'(peer_dly), 500);

    // placeholder flood
    for (int k = 0; k < 8; k++) do_op(0, 1, 0, 0, 0, 0, 0);
    chk("R5 flood dispersion", longint'(peer_disp), 15937500);
    chk("R5 flood delay", longint'(peer_dly), DMAX);
    chk("R5 flood flag", longint'(sync_ok), 0);
    do_op(1, 1, 0, 33, 50, 1, 1);
    chk("R5 sample beats placeholder", longint'(peer_dly), 50);
    chk("R5 sample offset", longint'(peer_off), 33);

    // randomized mix
    for (int k = 0; k < 400; k++) begin
      int r;
      bit s, d, t;
      r = int'($urandom_range(9));
      s = (r < 6) || (r == 8);
      d = (r == 6) || (r == 8);
      t = (r >= 7) || (r == 5) || ($urandom_range(3) == 0);
      do_op(s, d, t, longint'($urandom_range(100000)) - 50000,
            1000 + longint'($urandom_range(60000)),
            longint'($urandom_range(2000)), longint'($urandom_range(2000)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule